// File: doc/BRIEF.md
# Pseudo-Random Bit-Flip Injector

This block produces the flip masks that emulate single-event upsets in a protected byte register. A linear feedback shift register supplies the pattern. Each accepted injection strobe sends one 8-bit mask to the register's injection port for exactly one system clock cycle, together with a valid flag. The register XORs the mask into its stored value, so every 1 bit in the mask flips one stored bit. A mask with several 1 bits gives a multiple-bit upset.

Three modes are selected by a 2-bit code:
- **Off mode:** no injection takes place.
- **Seeded mode:** software writes a seed that names the exact bits to flip, then strobes once. The pattern is used up by that strobe and must be written again before the next one.
- **Free-running mode:** the shift register is seeded once. Every strobe then steps it and injects the new state as a pseudo-random pattern.

A build parameter can limit injection to the upper four data bits. In that case a 4-bit register drives mask bits 7..4 and the lower bits are never touched.

Top module: `fault_injector`

## Requirements
- R1: After reset, `flip_mask` is 0x00 and `flip_valid` is 0. The pattern register holds the value 1, so a free-running strobe with no seed write yields the successor of 1.
- R2: Mode code 0 (off) and the spare code 3 ignore `inj_strobe`. `flip_valid` stays 0, `flip_mask` stays 0x00, and the pattern register does not step.
- R3: Mode code 1 (seeded) behaves as follows. A strobe on clock edge k, with no seed write in that cycle, places the written pattern on `flip_mask` with `flip_valid` = 1 during the cycle after edge k. Seed bit i maps to mask bit i.
- R4: In seeded mode the strobe clears the pattern register. A further strobe with no new seed write gives `flip_valid` = 1 with mask 0x00.
- R5: Mode code 2 (free-running) behaves as follows. Each strobe first steps the pattern register once and then outputs the new state as the mask. The full-byte register computes new bit 0 as s7^s5^s4^s3 and shifts toward the MSB (x^8+x^6+x^5+x^4+1). The 4-bit register computes new bit 0 as s3^s2 (x^4+x^3+1).
- R6: In free-running mode an all-zero pattern is replaced by 1, both when a seed is written and before a step, so the register never locks at zero.
- R7: `flip_valid` is high for one cycle per accepted strobe. Whenever `flip_valid` is 0, `flip_mask` is 0x00.
- R8: With `HIGH_NIBBLE_ONLY` = 1, the pattern comes from `seed[7:4]` and drives `flip_mask[7:4]`. `flip_mask[3:0]` is always 0.
- R9: A seed write and a strobe in the same cycle load the seed and cause no injection. `flip_valid` is 0 in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode | input | 2 | 0 off, 1 seeded, 2 free-running, 3 spare (off) |
| seed_wr | input | 1 | Write `seed` into the pattern register |
| seed | input | 8 | Seed pattern; bit i selects mask bit i |
| inj_strobe | input | 1 | Injection request, one cycle per fault |
| flip_mask | output | 8 | Bits to flip in the protected register |
| flip_valid | output | 1 | Mask is to be applied this cycle |

## Verification
A corrupted pattern register shows up at the next accepted strobe. The mask then leaves the expected step sequence, or a seeded pattern comes back changed, one cycle after that strobe's edge. A wrong mode decode or a wrong priority between seed write and strobe shows up as a valid pulse that should not exist, or a missing one, in that same cycle. A failure to clear after a seeded strobe is only seen when the next strobe arrives with no fresh seed.

// File: rtl/fi_pkg.sv
// Shared types for the bit-flip injector.
// Assumes: mode codes are fixed by software convention.
package fi_pkg;
    typedef enum logic [1:0] {
        FI_OFF     = 2'd0,
        FI_SEEDED  = 2'd1,
        FI_RANDOM  = 2'd2,
        FI_SPARE   = 2'd3
    } fi_mode_e;

    localparam int FI_BYTE_W = 8;
endpackage

// File: rtl/fi_lfsr_step.sv
// One step of a Fibonacci shift register: shifts toward the MSB and
// builds the new bit 0 from the tap XOR.
// Assumes: W is 4 or 8; any other width falls back to a plain rotate.
module fi_lfsr_step #(
    parameter int W = 8
) (
    input  logic [W-1:0] cur,
    output logic [W-1:0] nxt
);
    logic fb;

    generate
        if (W == 8) begin : g_poly8
            // x^8+x^6+x^5+x^4+1
            assign fb = cur[7] ^ cur[5] ^ cur[4] ^ cur[3];
        end else if (W == 4) begin : g_poly4
            // x^4+x^3+1
            assign fb = cur[3] ^ cur[2];
        end else begin : g_rot
            assign fb = cur[W-1];
        end
    endgenerate

    assign nxt = {cur[W-2:0], fb};
endmodule

// File: rtl/fi_pattern_reg.sv
// Holds the current flip pattern. A seed write has priority; after that
// come a step (free-running mode) and a clear (seeded mode).
// Assumes: the top guarantees that step and clear are never both high.
module fi_pattern_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         step,
    input  logic [W-1:0] step_val,
    input  logic         clear,
    output logic [W-1:0] pattern
);
    localparam logic [W-1:0] RESET_VAL = W'(1);

    // Update the pattern: reset to 1, then seed write, step, clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pattern <= RESET_VAL;
        end else if (load) begin
            pattern <= load_val;
        end else if (step) begin
            pattern <= step_val;
        end else if (clear) begin
            pattern <= '0;
        end
    end
endmodule

// File: rtl/fi_mask_out.sv
// Registers the one-cycle flip mask and places a narrow pattern in the
// upper bits of the byte.
// Assumes: fire is a one-cycle request qualified by the top.
module fi_mask_out #(
    parameter int W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     fire,
    input  logic [W-1:0]             pattern,
    output logic [fi_pkg::FI_BYTE_W-1:0] mask,
    output logic                     valid
);
    localparam int PAD = fi_pkg::FI_BYTE_W - W;

    logic [fi_pkg::FI_BYTE_W-1:0] placed;

    generate
        if (PAD == 0) begin : g_full
            assign placed = pattern;
        end else begin : g_upper
            assign placed = {pattern, {PAD{1'b0}}};
        end
    endgenerate

    // Present the mask for one cycle per fire and drive zero otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask  <= '0;
            valid <= 1'b0;
        end else begin
            mask  <= fire ? placed : '0;
            valid <= fire;
        end
    end
endmodule

// File: rtl/fault_injector.sv
// Top of the bit-flip injector. Decodes the mode, chooses between the
// seeded and the free-running pattern, and issues one mask per strobe.
// Assumes: all inputs are synchronous to clk and the reset is active-low.
module fault_injector #(
    parameter bit HIGH_NIBBLE_ONLY = 1'b0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] mode,
    input  logic       seed_wr,
    input  logic [7:0] seed,
    input  logic       inj_strobe,
    output logic [7:0] flip_mask,
    output logic       flip_valid
);
    import fi_pkg::*;

    localparam int LW = HIGH_NIBBLE_ONLY ? 4 : 8;

    fi_mode_e     mode_e;
    logic         is_seeded;
    logic         is_random;
    logic         fire;
    logic [LW-1:0] seed_bits;
    logic [LW-1:0] load_val;
    logic [LW-1:0] pattern;
    logic [LW-1:0] step_src;
    logic [LW-1:0] step_nxt;
    logic [LW-1:0] inject_val;

    assign mode_e    = fi_mode_e'(mode);
    assign seed_bits = seed[FI_BYTE_W-1 -: LW];

    // Decode the mode and qualify the strobe; a seed write wins over it.
    always_comb begin
        is_seeded = (mode_e == FI_SEEDED);
        is_random = (mode_e == FI_RANDOM);
        fire      = inj_strobe && !seed_wr && (is_seeded || is_random);
    end

    // Replace zero patterns in free-running mode to avoid lock-up.
    always_comb begin
        load_val = (is_random && seed_bits == '0) ? LW'(1) : seed_bits;
        step_src = (pattern == '0) ? LW'(1) : pattern;
    end

    fi_lfsr_step #(.W(LW)) u_step (
        .cur (step_src),
        .nxt (step_nxt)
    );

    fi_pattern_reg #(.W(LW)) u_pat (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (seed_wr),
        .load_val (load_val),
        .step     (fire && is_random),
        .step_val (step_nxt),
        .clear    (fire && is_seeded),
        .pattern  (pattern)
    );

    // Pick the injected value: stepped state or the stored seed.
    always_comb begin
        inject_val = is_random ? step_nxt : pattern;
    end

    fi_mask_out #(.W(LW)) u_out (
        .clk     (clk),
        .rst_n   (rst_n),
        .fire    (fire),
        .pattern (inject_val),
        .mask    (flip_mask),
        .valid   (flip_valid)
    );
endmodule

// File: rtl/fault_injector_chk.sv
// Port-level properties of the bit-flip injector, bound to every instance.
// Assumes: the same parameter values as the bound top.
module fault_injector_chk #(
    parameter bit HIGH_NIBBLE_ONLY = 1'b0
) (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] mode,
    input logic       seed_wr,
    input logic [7:0] seed,
    input logic       inj_strobe,
    input logic [7:0] flip_mask,
    input logic       flip_valid
);
    logic seen;

    // Mark that one clock after reset has passed, so $past is meaningful.
    always_ff @(posedge clk) begin
        if (!rst_n) seen <= 1'b0;
        else        seen <= 1'b1;
    end

    // R7
    mask_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !flip_valid |-> flip_mask == 8'h00);

    // R7
    valid_follows_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seen && flip_valid |-> $past(inj_strobe));

    // R2
    off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seen && ($past(mode) == 2'd0 || $past(mode) == 2'd3) |-> !flip_valid);

    // R9
    load_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seen && $past(seed_wr) |-> !flip_valid);

    // R6
    random_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seen && flip_valid && $past(mode) == 2'd2 |-> flip_mask != 8'h00);

    // R8
    low_nibble_chk: assert property (@(posedge clk) disable iff (!rst_n)
        HIGH_NIBBLE_ONLY && seen |-> flip_mask[3:0] == 4'h0);
endmodule

bind fault_injector fault_injector_chk #(.HIGH_NIBBLE_ONLY(HIGH_NIBBLE_ONLY)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode       (mode),
    .seed_wr    (seed_wr),
    .seed       (seed),
    .inj_strobe (inj_strobe),
    .flip_mask  (flip_mask),
    .flip_valid (flip_valid)
);

// File: tb/fault_injector_test.sv
`timescale 1ns/1ps
module fault_injector_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] mode = 2'd0;
    logic       seed_wr = 1'b0;
    logic [7:0] seed = 8'h00;
    logic       inj_strobe = 1'b0;
    logic [7:0] mask_f, mask_h;
    logic       val_f, val_h;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    fault_injector uut (
        .clk(clk), .rst_n(rst_n), .mode(mode), .seed_wr(seed_wr), .seed(seed),
        .inj_strobe(inj_strobe), .flip_mask(mask_f), .flip_valid(val_f)
    );

    fault_injector #(.HIGH_NIBBLE_ONLY(1'b1)) uut_hi (
        .clk(clk), .rst_n(rst_n), .mode(mode), .seed_wr(seed_wr), .seed(seed),
        .inj_strobe(inj_strobe), .flip_mask(mask_h), .flip_valid(val_h)
    );

    function automatic logic [7:0] nx8(input logic [7:0] s);
        return {s[6:0], s[7] ^ s[5] ^ s[4] ^ s[3]};
    endfunction

    function automatic logic [3:0] nx4(input logic [3:0] s);
        return {s[2:0], s[3] ^ s[2]};
    endfunction

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    // Strobe once; afterwards the outputs of that edge are visible.
    task automatic strobe();
        inj_strobe = 1'b1;
        tick();
        inj_strobe = 1'b0;
    endtask

    task automatic write_seed(input logic [7:0] s);
        seed = s;
        seed_wr = 1'b1;
        tick();
        seed_wr = 1'b0;
    endtask

    // R1 reset state
    task automatic t_reset();
        rst_n = 1'b0;
        repeat (2) tick();
        rst_n = 1'b1;
        tick();
        chk("R1 mask", mask_f, 8'h00);
        chk("R1 valid", {7'd0, val_f}, 8'h00);
        chk("R1 hi mask", mask_h, 8'h00);
    endtask

    // R2 off and spare codes ignore the strobe; R1 reset pattern is 1
    task automatic t_off();
        mode = 2'd0;
        strobe();
        chk("R2 off valid", {7'd0, val_f}, 8'h00);
        chk("R2 off mask", mask_f, 8'h00);
        mode = 2'd3;
        strobe();
        chk("R2 spare valid", {7'd0, val_h}, 8'h00);
        mode = 2'd2;
        strobe();
        chk("R1 R2 untouched full", mask_f, nx8(8'h01));
        chk("R1 R2 untouched hi", mask_h, {nx4(4'h1), 4'h0});
    endtask

    // R3 seeded injection, R4 clear after use, R7 one-cycle pulse, R8 upper nibble
    task automatic t_seeded();
        mode = 2'd1;
        write_seed(8'hA5);
        strobe();
        chk("R3 seeded mask", mask_f, 8'hA5);
        chk("R3 seeded valid", {7'd0, val_f}, 8'h01);
        chk("R8 hi seeded mask", mask_h, 8'hA0);
        tick();
        chk("R7 valid drops", {7'd0, val_f}, 8'h00);
        chk("R7 mask drops", mask_f, 8'h00);
        strobe();
        chk("R4 cleared mask", mask_f, 8'h00);
        chk("R4 cleared valid", {7'd0, val_f}, 8'h01);
        write_seed(8'h10);
        strobe();
        chk("R3 single flip", mask_f, 8'h10);
        chk("R8 hi single flip", mask_h, 8'h10);
    endtask

    // R5 stepping sequence with back-to-back strobes, R6 zero seed
    task automatic t_random();
        logic [7:0] e8;
        logic [3:0] e4;
        mode = 2'd2;
        write_seed(8'h00);
        e8 = 8'h01;
        e4 = 4'h1;
        inj_strobe = 1'b1;
        for (int i = 0; i < 6; i++) begin
            tick();
            e8 = nx8(e8);
            e4 = nx4(e4);
            chk("R5 R6 random full", mask_f, e8);
            chk("R5 R6 random hi", mask_h, {e4, 4'h0});
            chk("R7 back-to-back valid", {7'd0, val_f}, 8'h01);
        end
        inj_strobe = 1'b0;
        tick();
        chk("R7 random idle", {7'd0, val_f}, 8'h00);
    endtask

    // R6 zero left by a seeded strobe is replaced before a random step
    task automatic t_zero_step();
        mode = 2'd1;
        write_seed(8'h0F);
        strobe();
        mode = 2'd2;
        strobe();
        chk("R6 zero step full", mask_f, nx8(8'h01));
        chk("R6 zero step hi", mask_h, {nx4(4'h1), 4'h0});
    endtask

    // R9 seed write and strobe together
    task automatic t_collide();
        mode = 2'd2;
        seed = 8'h3C;
        seed_wr = 1'b1;
        inj_strobe = 1'b1;
        tick();
        seed_wr = 1'b0;
        inj_strobe = 1'b0;
        chk("R9 no injection", {7'd0, val_f}, 8'h00);
        chk("R9 no injection hi", {7'd0, val_h}, 8'h00);
        strobe();
        chk("R9 seed loaded full", mask_f, nx8(8'h3C));
        chk("R9 seed loaded hi", mask_h, {nx4(4'h3), 4'h0});
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual timeout expected completion");
        finish_run();
    end

    initial begin
        t_reset();
        t_off();
        t_seeded();
        t_random();
        t_zero_step();
        t_collide();
        repeat (2) tick();
        finish_run();
    end
endmodule